// File: doc/BRIEF.md
# I3C Message Frame Sequencer

The sequencer sits in the controller side of an I3C bus engine running in single data rate mode. It accepts one 32-bit message control word at a time over a valid/ready handshake and expands it into an ordered stream of symbolic bus tokens: START, repeated START, STOP, arbitrable header, address with RnW, data byte with T bit, and the HDR exit pattern. A downstream bit-level engine consumes the tokens over a second valid/ready handshake and turns them into line activity. Electrical timing, drive-mode switching, acknowledge sampling, target behaviour and command decoding all belong to other blocks.

Three message kinds share one framing engine: private, direct and legacy I2C. A private or legacy message that opens the bus with START gets the arbitrable header (7'h7E with RnW=0, then a repeated START) unless the no-arbitration configuration bit is set. A private or legacy message that continues an open bus with a repeated START gets that header only when the message before it was a direct message that left the bus open. Direct messages always start with a repeated START and never carry the header. To make these choices, the block keeps two history bits: whether the bus was left open, and whether the message that left it open was direct. A fourth kind, the recovery message, emits only the exit pattern, and only when that pattern is enabled. Any other type code raises a sticky error flag.

FSM states: `ST_IDLE` (waiting for a word), `ST_LEAD` (START or repeated START), `ST_HDR` (header byte), `ST_HSR` (repeated START after the header), `ST_ADDR` (address plus RnW), `ST_DATA` (one token per data byte), `ST_TAIL` (closing STOP or repeated START) and `ST_EXIT` (exit pattern). The FSM leaves a token state only when that token is handed off. The transitions are:
- `ST_IDLE` to `ST_LEAD` when a framed word is accepted.
- `ST_IDLE` to `ST_EXIT` when an enabled recovery word is accepted.
- `ST_LEAD` to `ST_HDR` if a header is due, otherwise to `ST_ADDR`.
- `ST_HDR` to `ST_HSR`.
- `ST_HSR` to `ST_ADDR`.
- `ST_ADDR` to `ST_DATA` if the byte count is non-zero, otherwise to `ST_TAIL`.
- `ST_DATA` stays in `ST_DATA` until the last byte is handed off, then goes to `ST_TAIL`.
- `ST_TAIL` to `ST_IDLE`.
- `ST_EXIT` to `ST_IDLE`.

Top module: `msg_frame_seq`

## Requirements
- R1: The control word is decoded as follows:
  - bits [30:27] hold the message type: 4'b0001 is recovery, 4'b0010 is private, 4'b0011 is direct, 4'b0100 is legacy I2C;
  - bits [23:17] hold the address;
  - bit [16] holds RnW;
  - bits [15:0] hold the byte count;
  - bit 31 is ignored.

  Token codes on `tok_kind` are START=0, RSTART=1, STOP=2, HDR=3, ADDR=4, DATA=5, EXIT=6.
- R2: A private or legacy message on a closed bus with the no-arbitration bit clear starts with START, HDR (payload 16'h00FC), RSTART, ADDR.
- R3: With the no-arbitration bit set, such a message starts with START, ADDR.
- R4: On an open bus, a private or legacy message starts with RSTART, then HDR and RSTART only if the previous framed message was direct and ended without STOP, then ADDR. The no-arbitration bit has no effect here.
- R5: A direct message always starts with RSTART, ADDR, and never contains HDR, whatever the bus state and the no-arbitration bit.
- R6: A byte count N produces exactly N DATA tokens whose payloads are 0, 1, …, N-1, between ADDR and the closing token. N=0 produces none. N=65535 is supported.
- R7: Every framed message ends with STOP when its end-with-stop flag is set, otherwise with RSTART. `tok_last` is high on that token only. The ending decides the bus state seen by the next message.
- R8: A recovery word with the exit enable set produces a single EXIT token with `tok_last` high, whatever bits [26:0] contain. With the enable clear it produces no token. It does not change the bus history.
- R9: Any other type code (0, 5 to 15) produces no token, leaves the bus history unchanged, and sets `err_flag`, which stays high until reset.
- R10: `cw_ready` is low from the accepted word until the cycle after its final token is handed off. While `tok_valid` is high and `tok_ready` is low, the token and its payload hold.
- R11: After reset, `cw_ready` is 1, `tok_valid` is 0, `err_flag` is 0, and the bus is treated as closed.
- R12: The ADDR token payload is {8'h00, address, RnW}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 1 | Control word offered |
| cw_ready | output | 1 | Sequencer can take a control word |
| cw_word | input | 32 | Message control word |
| cfg_no_arb | input | 1 | Suppress the header after START (sampled with the word) |
| cfg_exit_en | input | 1 | Allow the exit pattern for recovery words (sampled with the word) |
| cw_end_stop | input | 1 | End this message with STOP rather than RSTART |
| tok_valid | output | 1 | Token offered |
| tok_ready | input | 1 | Token consumer ready |
| tok_kind | output | 3 | Token code (R1) |
| tok_payload | output | 16 | Header byte, address byte, or data byte index |
| tok_last | output | 1 | Final token of the message |
| err_flag | output | 1 | Sticky illegal-type flag |

## Verification
The bench builds the block with its default 16-bit count width. This keeps the largest count, 65535, within reach, so the long data phase and its index sequence are run once with the consumer always ready. The main sweep runs every framed type against both no-arbitration settings, both endings and counts 0 to 3, under a pseudo-random stall pattern on `tok_ready`. Because the messages follow each other, every closed/open and direct/non-direct history combination is reached. Directed sequences cover the direct-then-private header insertion, all sixteen type codes, and the exit enable.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

    typedef enum logic [2:0] {
        TK_START  = 3'd0,
        TK_RSTART = 3'd1,
        TK_STOP   = 3'd2,
        TK_HDR    = 3'd3,
        TK_ADDR   = 3'd4,
        TK_DATA   = 3'd5,
        TK_EXIT   = 3'd6
    } tok_e;

    typedef enum logic [2:0] {
        MK_RECOVER,
        MK_PRIVATE,
        MK_DIRECT,
        MK_LEGACY,
        MK_BAD
    } msg_kind_e;

    localparam logic [3:0] CODE_RECOVER = 4'b0001;
    localparam logic [3:0] CODE_PRIVATE = 4'b0010;
    localparam logic [3:0] CODE_DIRECT  = 4'b0011;
    localparam logic [3:0] CODE_LEGACY  = 4'b0100;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 7;

endpackage

// File: rtl/mfs_decode.sv
module mfs_decode
    import mfs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [WORD_W-1:0] word,
    input  logic              no_arb,
    input  logic              bus_open,
    input  logic              dir_open,
    output msg_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic              rnw,
    output logic [CNT_W-1:0]  cnt,
    output logic              lead_sr,
    output logic              want_hdr
);
    logic [3:0] code;
    logic       unused_bits;

    assign code        = word[30:27];
    assign addr        = word[23:17];
    assign rnw         = word[16];
    assign cnt         = word[CNT_W-1:0];
    assign unused_bits = ^{word[31], word[26:24], word[15:CNT_W]};

    always_comb begin
        unique case (code)
            CODE_RECOVER: kind = MK_RECOVER;
            CODE_PRIVATE: kind = MK_PRIVATE;
            CODE_DIRECT:  kind = MK_DIRECT;
            CODE_LEGACY:  kind = MK_LEGACY;
            default:      kind = MK_BAD;
        endcase
    end

    always_comb begin
        lead_sr  = 1'b1;
        want_hdr = 1'b0;
        if (kind == MK_PRIVATE || kind == MK_LEGACY) begin
            lead_sr  = bus_open;
            want_hdr = bus_open ? dir_open : !no_arb;
        end
    end
endmodule

// File: rtl/mfs_history.sv
module mfs_history (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic ended_stop,
    input  logic was_direct,
    output logic bus_open,
    output logic dir_open
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_open <= 1'b0;
            dir_open <= 1'b0;
        end else if (upd) begin
            bus_open <= !ended_stop;
            dir_open <= was_direct && !ended_stop;
        end
    end
endmodule

// File: rtl/mfs_byte_ctr.sv
module mfs_byte_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] idx,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (inc) idx <= idx + ONE;
    end

    assign at_last = (idx == total - ONE);
endmodule

// File: rtl/msg_frame_seq.sv
module msg_frame_seq
    import mfs_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter logic [6:0]  ARB_HDR = 7'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_valid,
    output logic              cw_ready,
    input  logic [31:0]       cw_word,
    input  logic              cfg_no_arb,
    input  logic              cfg_exit_en,
    input  logic              cw_end_stop,
    output logic              tok_valid,
    input  logic              tok_ready,
    output logic [2:0]        tok_kind,
    output logic [CNT_W-1:0]  tok_payload,
    output logic              tok_last,
    output logic              err_flag
);
    localparam int PAD_W = CNT_W - 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_HDR, ST_HSR, ST_ADDR, ST_DATA, ST_TAIL, ST_EXIT
    } state_e;

    state_e state, state_nx;

    msg_kind_e         d_kind;
    logic [ADDR_W-1:0] d_addr;
    logic              d_rnw;
    logic [CNT_W-1:0]  d_cnt;
    logic              d_lead_sr, d_want_hdr;
    logic              bus_open, dir_open;

    logic [ADDR_W-1:0] m_addr;
    logic              m_rnw, m_stop, m_direct, m_lead_sr, m_hdr;
    logic [CNT_W-1:0]  m_cnt;

    logic              take, fire;
    logic [CNT_W-1:0]  byte_idx;
    logic              byte_last;

    assign cw_ready = (state == ST_IDLE);
    assign take     = cw_valid && cw_ready;
    assign fire     = tok_valid && tok_ready;

    mfs_decode #(.CNT_W(CNT_W)) u_dec (
        .word     (cw_word),
        .no_arb   (cfg_no_arb),
        .bus_open (bus_open),
        .dir_open (dir_open),
        .kind     (d_kind),
        .addr     (d_addr),
        .rnw      (d_rnw),
        .cnt      (d_cnt),
        .lead_sr  (d_lead_sr),
        .want_hdr (d_want_hdr)
    );

    mfs_history u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (state == ST_TAIL && fire),
        .ended_stop (m_stop),
        .was_direct (m_direct),
        .bus_open   (bus_open),
        .dir_open   (dir_open)
    );

    mfs_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take),
        .inc     (state == ST_DATA && fire),
        .total   (m_cnt),
        .idx     (byte_idx),
        .at_last (byte_last)
    );

    // Message latch: fields held for the life of one message.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr    <= '0;
            m_rnw     <= 1'b0;
            m_cnt     <= '0;
            m_stop    <= 1'b0;
            m_direct  <= 1'b0;
            m_lead_sr <= 1'b0;
            m_hdr     <= 1'b0;
        end else if (take) begin
            m_addr    <= d_addr;
            m_rnw     <= d_rnw;
            m_cnt     <= d_cnt;
            m_stop    <= cw_end_stop;
            m_direct  <= (d_kind == MK_DIRECT);
            m_lead_sr <= d_lead_sr;
            m_hdr     <= d_want_hdr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         err_flag <= 1'b0;
        else if (take && d_kind == MK_BAD)  err_flag <= 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    unique case (d_kind)
                        MK_PRIVATE, MK_DIRECT, MK_LEGACY: state_nx = ST_LEAD;
                        MK_RECOVER: state_nx = cfg_exit_en ? ST_EXIT : ST_IDLE;
                        default:    state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_LEAD: if (fire) state_nx = m_hdr ? ST_HDR : ST_ADDR;
            ST_HDR:  if (fire) state_nx = ST_HSR;
            ST_HSR:  if (fire) state_nx = ST_ADDR;
            ST_ADDR: if (fire) state_nx = (m_cnt == '0) ? ST_TAIL : ST_DATA;
            ST_DATA: if (fire && byte_last) state_nx = ST_TAIL;
            ST_TAIL: if (fire) state_nx = ST_IDLE;
            ST_EXIT: if (fire) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Token outputs
    always_comb begin
        tok_valid   = 1'b1;
        tok_last    = 1'b0;
        tok_kind    = TK_START;
        tok_payload = '0;
        unique case (state)
            ST_IDLE: tok_valid = 1'b0;
            ST_LEAD: tok_kind  = m_lead_sr ? TK_RSTART : TK_START;
            ST_HDR: begin
                tok_kind    = TK_HDR;
                tok_payload = {{PAD_W{1'b0}}, ARB_HDR, 1'b0};
            end
            ST_HSR:  tok_kind = TK_RSTART;
            ST_ADDR: begin
                tok_kind    = TK_ADDR;
                tok_payload = {{PAD_W{1'b0}}, m_addr, m_rnw};
            end
            ST_DATA: begin
                tok_kind    = TK_DATA;
                tok_payload = byte_idx;
            end
            ST_TAIL: begin
                tok_kind = m_stop ? TK_STOP : TK_RSTART;
                tok_last = 1'b1;
            end
            ST_EXIT: begin
                tok_kind = TK_EXIT;
                tok_last = 1'b1;
            end
            default: tok_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/msg_frame_seq_chk.sv
module msg_frame_seq_chk
    import mfs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cw_ready,
    input logic             tok_valid,
    input logic             tok_ready,
    input logic [2:0]       tok_kind,
    input logic [CNT_W-1:0] tok_payload,
    input logic             tok_last,
    input logic             err_flag
);
    assert_busy_blocks_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> !cw_ready);

    assert_token_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !tok_ready |=> tok_valid && $stable(tok_kind) && $stable(tok_payload)
                                    && $stable(tok_last));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_hdr_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_HDR |-> tok_payload == CNT_W'(16'h00FC) && !tok_last);

    assert_last_is_closer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_last |-> tok_kind == TK_STOP || tok_kind == TK_RSTART
                                  || tok_kind == TK_EXIT);

    assert_exit_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_EXIT |-> tok_last);

    assert_data_not_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_ready && tok_kind == TK_DATA |=> tok_valid);

    assert_hdr_then_rstart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_ready && tok_kind == TK_HDR |=> tok_valid && tok_kind == TK_RSTART);
endmodule

bind msg_frame_seq msg_frame_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cw_ready    (cw_ready),
    .tok_valid   (tok_valid),
    .tok_ready   (tok_ready),
    .tok_kind    (tok_kind),
    .tok_payload (tok_payload),
    .tok_last    (tok_last),
    .err_flag    (err_flag)
);

// File: tb/msg_frame_seq_test.sv
module msg_frame_seq_test;
    import mfs_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, cw_valid, cw_ready, cfg_no_arb, cfg_exit_en, cw_end_stop;
    logic [31:0] cw_word;
    logic        tok_valid, tok_ready, tok_last, err_flag;
    logic [2:0]  tok_kind;
    logic [15:0] tok_payload;

    msg_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
        .cw_word(cw_word), .cfg_no_arb(cfg_no_arb), .cfg_exit_en(cfg_exit_en),
        .cw_end_stop(cw_end_stop), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_kind(tok_kind), .tok_payload(tok_payload), .tok_last(tok_last),
        .err_flag(err_flag)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Collected tokens of the current message
    logic [2:0]  lg_k [0:31];
    logic [15:0] lg_p [0:31];
    int ntok, dnext, seq_err, stall_err, last_at;
    bit done, bp_en, held;
    logic [2:0]  hk;
    logic [15:0] hp;
    logic [7:0]  lfsr;

    // Expected tokens from the bench model
    logic [2:0]  ex_k [0:31];
    logic [15:0] ex_p [0:31];
    int ex_n;
    bit m_open = 1'b0, m_dopen = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] k, input logic [15:0] p);
        if (ex_n < 32) begin
            ex_k[ex_n] = k;
            ex_p[ex_n] = p;
        end
        ex_n++;
    endtask

    initial begin
        tok_ready = 1'b1;
        lfsr = 8'h5A;
        held = 1'b0;
        forever begin
            @(negedge clk);
            if (bp_en) begin
                tok_ready = lfsr[0] | lfsr[3];
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end else begin
                tok_ready = 1'b1;
            end
            #1;
            if (held && (!tok_valid || tok_kind != hk || tok_payload != hp)) stall_err++;
            held = tok_valid && !tok_ready;
            hk = tok_kind;
            hp = tok_payload;
            if (tok_valid && tok_ready) begin
                if (ntok < 32) begin
                    lg_k[ntok] = tok_kind;
                    lg_p[ntok] = tok_payload;
                end
                if (tok_kind == TK_DATA) begin
                    if (tok_payload != 16'(dnext)) seq_err++;
                    dnext++;
                end
                if (tok_last) begin
                    if (last_at < 0) last_at = ntok;
                    done = 1'b1;
                end
                ntok++;
            end
        end
    end

    task automatic run_msg(input logic [31:0] w, input bit na, input bit ex,
                           input bit st, input string req);
        logic [3:0] code;
        int mism, to;
        bit bad;
        code = w[30:27];
        ex_n = 0;
        bad  = 1'b0;
        if (code == 4'd2 || code == 4'd4) begin
            if (!m_open) begin
                push(TK_START, 16'h0);
                if (!na) begin push(TK_HDR, 16'h00FC); push(TK_RSTART, 16'h0); end
            end else begin
                push(TK_RSTART, 16'h0);
                if (m_dopen) begin push(TK_HDR, 16'h00FC); push(TK_RSTART, 16'h0); end
            end
        end else if (code == 4'd3) begin
            push(TK_RSTART, 16'h0);
        end
        if (code >= 4'd2 && code <= 4'd4) begin
            push(TK_ADDR, {8'h00, w[23:16]});
            for (int i = 0; i < int'(w[15:0]); i++) push(TK_DATA, 16'(i));
            push(st ? TK_STOP : TK_RSTART, 16'h0);
            m_dopen = (code == 4'd3) && !st;
            m_open  = !st;
        end else if (code == 4'd1) begin
            if (ex) push(TK_EXIT, 16'h0);
        end else begin
            bad = 1'b1;
        end

        ntok = 0; dnext = 0; seq_err = 0; stall_err = 0; last_at = -1; done = 1'b0;
        @(negedge clk);
        cw_word = w; cfg_no_arb = na; cfg_exit_en = ex; cw_end_stop = st; cw_valid = 1'b1;
        @(posedge clk);
        #1 cw_valid = 1'b0;
        if (ex_n > 0) begin
            to = 0;
            while (!done && to < ex_n * 8 + 50) begin
                @(negedge clk); #2; to++;
            end
            @(posedge clk); #1;
        end else begin
            repeat (10) @(negedge clk);
        end

        chk(ntok == ex_n, req, "token count", ntok, ex_n);
        if (ex_n > 0) begin
            mism = -1;
            for (int i = 0; i < 32 && i < ex_n && i < ntok; i++)
                if (mism < 0 && (lg_k[i] != ex_k[i] || lg_p[i] != ex_p[i])) mism = i;
            if (mism >= 0)
                chk(1'b0, req, $sformatf("token %0d kind/payload", mism),
                    {lg_k[mism], lg_p[mism]}, {ex_k[mism], ex_p[mism]});
            else
                chk(1'b1, req, "token order", 0, 0);
            chk(last_at == ex_n - 1, "R7", "tok_last position", last_at, ex_n - 1);
            chk(seq_err == 0, "R6", "data index sequence errors", seq_err, 0);
            chk(stall_err == 0, "R10", "token changed while stalled", stall_err, 0);
        end
        if (bad) begin
            chk(err_flag == 1'b1, "R9", "err_flag after illegal type", err_flag, 1);
            chk(cw_ready == 1'b1, "R9", "cw_ready after illegal type", cw_ready, 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cw_valid = 1'b0; cw_word = '0;
        cfg_no_arb = 1'b0; cfg_exit_en = 1'b0; cw_end_stop = 1'b0; bp_en = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cw_ready == 1'b1, "R11", "cw_ready after reset", cw_ready, 1);
        chk(tok_valid == 1'b0, "R11", "tok_valid after reset", tok_valid, 0);
        chk(err_flag == 1'b0, "R11", "err_flag after reset", err_flag, 0);

        // R11/R2: first private message sees a closed bus
        run_msg({1'b0, 4'd2, 3'b000, 7'h2B, 1'b0, 16'd1}, 1'b0, 1'b0, 1'b1, "R11 R2");

        // Sweep under back-pressure: R2 R3 R4 R5 R6 R7 R12
        bp_en = 1'b1;
        for (int t = 0; t < 3; t++)
            for (int n = 0; n < 4; n++)
                for (int na = 0; na < 2; na++)
                    for (int st = 0; st < 2; st++) begin
                        logic [3:0] c;
                        logic [6:0] a;
                        c = (t == 0) ? 4'd2 : (t == 1) ? 4'd3 : 4'd4;
                        a = 7'(13 * t + 5 * n + na + 33);
                        run_msg({1'b0, c, 3'b000, a, 1'(n ^ st), 16'(n)}, na[0], 1'b0,
                                st[0], "R2/R3/R4/R5/R6/R12 sweep");
                    end

        // R4: direct left open, then private gets header after RSTART
        run_msg({1'b0, 4'd3, 3'b000, 7'h11, 1'b1, 16'd2}, 1'b1, 1'b0, 1'b0, "R5 direct open");
        run_msg({1'b0, 4'd2, 3'b000, 7'h12, 1'b0, 16'd1}, 1'b1, 1'b0, 1'b0, "R4 hdr after direct");
        // R4: private left open, legacy follows without header
        run_msg({1'b0, 4'd4, 3'b000, 7'h13, 1'b1, 16'd0}, 1'b0, 1'b0, 1'b1, "R4 no hdr after private");
        // R1: bit 31 ignored
        run_msg({1'b1, 4'd2, 3'b111, 7'h7F, 1'b1, 16'd2}, 1'b0, 1'b0, 1'b1, "R1 bit31 ignored");

        // R8: exit pattern, with garbage low bits; then disabled
        run_msg({1'b0, 4'd1, 27'h5A5A5A5}, 1'b0, 1'b1, 1'b0, "R8 exit enabled");
        run_msg({1'b0, 4'd1, 27'h7FFFFFF}, 1'b0, 1'b0, 1'b0, "R8 exit disabled");
        chk(err_flag == 1'b0, "R8", "err_flag after recovery word", err_flag, 0);
        // R8: history unchanged (bus closed, so START follows)
        run_msg({1'b0, 4'd2, 3'b000, 7'h05, 1'b0, 16'd0}, 1'b0, 1'b0, 1'b0, "R8 history kept");

        // R9: every illegal code; open bus from previous message must survive
        for (int c = 0; c < 16; c++)
            if (c == 0 || c > 4)
                run_msg({1'b0, 4'(c), 27'h1234567}, 1'b0, 1'b1, 1'b0, "R9 illegal type");
        run_msg({1'b0, 4'd4, 3'b000, 7'h06, 1'b0, 16'd1}, 1'b0, 1'b0, 1'b1, "R9 history kept");
        chk(err_flag == 1'b1, "R9", "err_flag sticky after legal message", err_flag, 1);

        // R6: largest count, consumer always ready
        bp_en = 1'b0;
        run_msg({1'b0, 4'd2, 3'b000, 7'h33, 1'b0, 16'hFFFF}, 1'b1, 1'b0, 1'b1, "R6 max count");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule